// File: doc/BRIEF.md
# UART Bus Front End with Programmable Baud Tick

This block sits between a small CPU-style parallel bus and the serial halves of a UART. Four active-low inputs (an asynchronous reset and three strobes: write, divisor load and read) steer a single shared 8-bit data bus. A divisor-load strobe puts the bus byte into a divisor register. A write strobe hands the bus byte to the transmitter, but only while the transmitter reports an empty buffer. A read strobe returns the last received byte together with its ready, parity-error and framing-error flags.

A reload counter divides the system clock by (divisor + 1) and emits a one-cycle enable at sixteen times the bit rate. The transmitter and the receiver both use this enable. The divisor equals f_clk / (16 * baud) - 1. For example, a 1.6 MHz clock at 10000 baud takes the value 9. Each strobe takes effect once, in the first cycle it is seen low, however long it stays low. The strobes are assumed to be synchronous to the clock.

Top module: `uart_bus_front`

## Requirements
- R1: After reset the divisor is DIV_RST (9), the tick is low, no transmit load is issued, and the read outputs and the stored receive status are all zero.
- R2: With divisor D the tick is high for exactly one cycle in every D+1 cycles. When D is 0 the tick is high on every cycle.
- R3: A divisor load restarts the count from zero. The first tick appears D+1 cycles after the clock edge that takes the load, and the same D+1 spacing follows.
- R4: A write strobe while tx_empty_i is 1 drives tx_load_o high for one cycle, one clock after the strobe is taken. tx_data_o carries the bus byte at that time.
- R5: A write strobe while tx_empty_i is 0 is ignored. tx_load_o stays low and tx_data_o keeps its previous value.
- R6: A strobe held low for several cycles acts only once. It acts again only after it has returned high.
- R7: A read strobe copies the stored byte and the ready, parity-error and framing-error flags to the read outputs, one clock after the strobe is taken. It then clears the three flags, so a second read shows ready 0 with the same byte.
- R8: A frame that arrives (rx_valid_i high) in the same cycle as a read is kept. The read returns the earlier status, and the next read returns the new frame with ready 1.
- R9: If the divisor-load and write strobes are taken in the same cycle, the divisor is loaded and the write is dropped.
- R10: The parity-error and framing-error flags are latched from rx_perr_i and rx_ferr_i together with each received byte. A later clean frame clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_data_i | input | 8 | Shared bus byte: divisor or transmit data |
| wr_ni | input | 1 | Transmit write strobe, active low |
| baud_ld_ni | input | 1 | Divisor load strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| tick_o | output | 1 | One-cycle enable at 16x bit rate |
| tx_empty_i | input | 1 | Transmitter buffer empty |
| tx_load_o | output | 1 | One-cycle load pulse to transmitter |
| tx_data_o | output | 8 | Byte handed to transmitter |
| rx_valid_i | input | 1 | Receiver frame complete, one cycle |
| rx_data_i | input | 8 | Received byte |
| rx_perr_i | input | 1 | Parity error of this frame |
| rx_ferr_i | input | 1 | Stop-bit error of this frame |
| rd_data_o | output | 8 | Byte returned by last read |
| rd_ready_o | output | 1 | Ready flag returned by last read |
| rd_perr_o | output | 1 | Parity-error flag returned by last read |
| rd_ferr_o | output | 1 | Framing-error flag returned by last read |

## Verification
The hardest case to reach from the ports is a collision inside one cycle: a frame arriving during a read, or a divisor load during a write. Random traffic almost never lines these up. Directed steps drive both inputs at the same falling clock edge, then issue follow-up reads or watch the tick spacing to show which action won. Randomised divisor loads, which restart the counter mid-period, are timed by counting cycles up to the first tick and the second tick.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              ready;
    logic              perr;
    logic              ferr;
  } rx_status_t;
endpackage

// File: rtl/ufe_strobe_edge.sv
// First-low-cycle detector for a group of active-low strobes.
module ufe_strobe_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strobe_ni,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b1;
      else         prev_q[i] <= strobe_ni[i];
    end
    assign fall_o[i] = prev_q[i] & ~strobe_ni[i];
  end
endmodule

// File: rtl/ufe_baud_div.sv
module ufe_baud_div #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] div_o,
  output logic [DIV_W-1:0] cnt_o
);
  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(DIV_RST);

  logic [DIV_W-1:0] div_q, cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= RST_VAL;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (ld_i) begin
      div_q  <= div_i;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == div_q) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
  assign div_o  = div_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ufe_tx_gate.sv
module ufe_tx_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              block_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o
);
  logic              load_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = wr_i & ~block_i & empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      data_q <= '0;
    end else begin
      load_q <= accept;
      if (accept) data_q <= data_i;
    end
  end

  assign load_o = load_q;
  assign data_o = data_q;
endmodule

// File: rtl/ufe_rx_status.sv
module ufe_rx_status
  import uart_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rd_i,
  output rx_status_t        sts_o,
  output rx_status_t        rd_o
);
  rx_status_t sts_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      rd_q  <= '0;
    end else begin
      if (rd_i) begin
        rd_q       <= sts_q;
        sts_q.ready <= 1'b0;
        sts_q.perr  <= 1'b0;
        sts_q.ferr  <= 1'b0;
      end
      // a new frame in the read cycle overrides the clear
      if (rx_valid_i) begin
        sts_q.data  <= rx_data_i;
        sts_q.ready <= 1'b1;
        sts_q.perr  <= rx_perr_i;
        sts_q.ferr  <= rx_ferr_i;
      end
    end
  end

  assign sts_o = sts_q;
  assign rd_o  = rd_q;
endmodule

// File: rtl/uart_bus_front.sv
module uart_bus_front
  import uart_fe_pkg::*;
#(
  parameter int unsigned DIV_RST = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] bus_data_i,
  input  logic              wr_ni,
  input  logic              baud_ld_ni,
  input  logic              rd_ni,
  output logic              tick_o,
  input  logic              tx_empty_i,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_ready_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o
);
  localparam int unsigned N_STB = 3;
  localparam int unsigned S_WR = 0, S_LD = 1, S_RD = 2;

  logic [N_STB-1:0]  stb_n, stb_fall;
  logic              wr_fall, ld_fall, rd_fall;
  logic [BYTE_W-1:0] div_q, cnt_q;
  rx_status_t        sts_q, rd_q;

  assign stb_n[S_WR] = wr_ni;
  assign stb_n[S_LD] = baud_ld_ni;
  assign stb_n[S_RD] = rd_ni;

  ufe_strobe_edge #(.N(N_STB)) u_edge (
    .clk_i, .rst_ni, .strobe_ni(stb_n), .fall_o(stb_fall)
  );

  assign wr_fall = stb_fall[S_WR];
  assign ld_fall = stb_fall[S_LD];
  assign rd_fall = stb_fall[S_RD];

  ufe_baud_div #(.DIV_W(BYTE_W), .DIV_RST(DIV_RST)) u_div (
    .clk_i, .rst_ni, .ld_i(ld_fall), .div_i(bus_data_i),
    .tick_o, .div_o(div_q), .cnt_o(cnt_q)
  );

  ufe_tx_gate #(.DATA_W(BYTE_W)) u_tx (
    .clk_i, .rst_ni, .wr_i(wr_fall), .block_i(ld_fall), .empty_i(tx_empty_i),
    .data_i(bus_data_i), .load_o(tx_load_o), .data_o(tx_data_o)
  );

  ufe_rx_status u_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .rx_perr_i, .rx_ferr_i,
    .rd_i(rd_fall), .sts_o(sts_q), .rd_o(rd_q)
  );

  assign rd_data_o  = rd_q.data;
  assign rd_ready_o = rd_q.ready;
  assign rd_perr_o  = rd_q.perr;
  assign rd_ferr_o  = rd_q.ferr;
endmodule

// File: rtl/ufe_checker.sv
module ufe_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         tx_load_i,
  input logic         tx_empty_i,
  input logic         wr_ni,
  input logic         ld_fall_i,
  input logic         rd_fall_i,
  input logic         rx_valid_i,
  input logic         sts_ready_i,
  input logic [W-1:0] div_i,
  input logic [W-1:0] cnt_i
);
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && div_i != '0) |=> !tick_i); // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= div_i); // R2
  AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fall_i |=> (cnt_i == '0 && !tick_i)); // R3
  AST_TX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> !tx_load_i); // R4
  AST_TX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |-> ($past(tx_empty_i) && !$past(wr_ni))); // R5
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |-> !$past(ld_fall_i)); // R9
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fall_i && !rx_valid_i) |=> !sts_ready_i); // R7
  AST_FRAME_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> sts_ready_i); // R8
endmodule

bind uart_bus_front ufe_checker #(.W(8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_o), .tx_load_i(tx_load_o),
  .tx_empty_i(tx_empty_i), .wr_ni(wr_ni), .ld_fall_i(ld_fall),
  .rd_fall_i(rd_fall), .rx_valid_i(rx_valid_i), .sts_ready_i(sts_q.ready),
  .div_i(div_q), .cnt_i(cnt_q)
);

// File: tb/uart_bus_front_tb_top.sv
`timescale 1ns/1ps
module uart_bus_front_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] bus_data_i = '0;
  logic       wr_ni = 1'b1, baud_ld_ni = 1'b1, rd_ni = 1'b1;
  logic       tick_o, tx_empty_i = 1'b1, tx_load_o;
  logic [7:0] tx_data_o, rx_data_i = '0, rd_data_o;
  logic       rx_valid_i = 1'b0, rx_perr_i = 1'b0, rx_ferr_i = 1'b0;
  logic       rd_ready_o, rd_perr_o, rd_ferr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // model of stored receive status
  logic [7:0] m_byte = '0;
  logic       m_rdy = 0, m_pe = 0, m_fe = 0;
  logic [7:0] m_tx = '0;

  always #4 clk_i = ~clk_i;

  uart_bus_front dut_i (.*);

  function automatic logic [10:0] pack_sts(logic [7:0] b, logic r, logic p, logic f);
    return {b, r, p, f};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_div(logic [7:0] d);
    @(negedge clk_i); baud_ld_ni = 1'b0; bus_data_i = d;
    @(negedge clk_i); baud_ld_ni = 1'b1;
  endtask

  // counts cycles from the negedge after the load edge to the next tick
  task automatic tick_gap(output int n);
    n = 0;
    do begin
      @(negedge clk_i); n++;
    end while (!tick_o && n < 300);
  endtask

  task automatic check_rate(string req, logic [7:0] d);
    int n;
    load_div(d);
    tick_gap(n); chk(req, n, d + 1);
    tick_gap(n); chk(req, n, d + 1);
  endtask

  task automatic do_write(string req, logic [7:0] b, logic empty);
    @(negedge clk_i); wr_ni = 1'b0; bus_data_i = b; tx_empty_i = empty;
    @(negedge clk_i); wr_ni = 1'b1;
    if (empty) m_tx = b;
    chk(req, tx_load_o, empty);
    chk(req, tx_data_o, m_tx);
    @(negedge clk_i); chk(req, tx_load_o, 1'b0);
  endtask

  task automatic rx_frame(logic [7:0] b, logic p, logic f);
    @(negedge clk_i); rx_valid_i = 1'b1; rx_data_i = b; rx_perr_i = p; rx_ferr_i = f;
    @(negedge clk_i); rx_valid_i = 1'b0;
    m_byte = b; m_rdy = 1; m_pe = p; m_fe = f;
  endtask

  task automatic do_read(string req);
    @(negedge clk_i); rd_ni = 1'b0;
    @(negedge clk_i); rd_ni = 1'b1;
    chk(req, pack_sts(rd_data_o, rd_ready_o, rd_perr_o, rd_ferr_o),
        pack_sts(m_byte, m_rdy, m_pe, m_fe));
    m_rdy = 0; m_pe = 0; m_fe = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i); cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {tick_o, tx_load_o, rd_data_o, rd_ready_o, rd_perr_o, rd_ferr_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    tick_gap(n); // align to a tick, then default period
    tick_gap(n); chk("R1", n, 10);

    // R2 / R3 directed corners
    check_rate("R2", 8'd0);
    check_rate("R3", 8'd9);
    check_rate("R3", 8'd1);
    for (int i = 0; i < 6; i++) check_rate("R3", 8'($urandom_range(0, 40)));

    // R4 / R5
    do_write("R4", 8'hA5, 1'b1);
    do_write("R5", 8'h3C, 1'b0);

    // R6 write held low acts once
    @(negedge clk_i); wr_ni = 1'b0; bus_data_i = 8'h5A; tx_empty_i = 1'b1;
    @(negedge clk_i); chk("R6", tx_load_o, 1'b1);
    @(negedge clk_i); chk("R6", tx_load_o, 1'b0);
    @(negedge clk_i); chk("R6", tx_load_o, 1'b0);
    wr_ni = 1'b1; m_tx = 8'h5A;
    @(negedge clk_i); chk("R6", tx_load_o, 1'b0);

    // R9 load and write together: load wins
    @(negedge clk_i); wr_ni = 1'b0; baud_ld_ni = 1'b0; bus_data_i = 8'd4; tx_empty_i = 1'b1;
    @(negedge clk_i); wr_ni = 1'b1; baud_ld_ni = 1'b1;
    chk("R9", tx_load_o, 1'b0);
    chk("R9", tx_data_o, m_tx);
    tick_gap(n); chk("R9", n, 5);

    // R7 / R10 read and clear
    rx_frame(8'hC3, 1'b1, 1'b0);
    do_read("R10");
    do_read("R7");
    rx_frame(8'h11, 1'b0, 1'b1);
    do_read("R10");
    rx_frame(8'h22, 1'b0, 1'b0);
    do_read("R10");

    // R8 frame during read
    rx_frame(8'h77, 1'b1, 1'b1);
    @(negedge clk_i); rd_ni = 1'b0; rx_valid_i = 1'b1; rx_data_i = 8'h99;
    rx_perr_i = 1'b0; rx_ferr_i = 1'b0;
    @(negedge clk_i); rd_ni = 1'b1; rx_valid_i = 1'b0;
    chk("R8", pack_sts(rd_data_o, rd_ready_o, rd_perr_o, rd_ferr_o),
        pack_sts(8'h77, 1'b1, 1'b1, 1'b1));
    m_byte = 8'h99; m_rdy = 1; m_pe = 0; m_fe = 0;
    do_read("R8");

    // random mix
    for (int i = 0; i < 60; i++) begin
      case ($urandom_range(0, 2))
        0: do_write("R5", 8'($urandom), 1'($urandom));
        1: rx_frame(8'($urandom), 1'($urandom), 1'($urandom));
        default: do_read("R7");
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule